// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a watchdog timer on a simple register bus: write and read strobes, a word address and 32-bit data in each direction. Three words are visible: a control/status word at word 0, a key/counter word at word 1 and a timeout word at word 2 (byte offset 0x8). Software keeps the watchdog alive by writing a refresh key to the counter word. If it fails to do so in time, the block raises a sticky reset request. Any write to the counter word that is not a recognised key also raises the request.

The count, the timeout and the enable setting are guarded. Changing them first requires an unlock key written to the counter word. That key opens a short window. Inside the window, the timeout word may be rewritten freely. The first write to the control word is accepted and then closes the window. Each key can be sent in two forms. One is a single 32-bit word, honoured only while the 32-bit command bit is set. The other is two 16-bit halves written in order. The counter advances once per 1 ms tick, and the tick is derived from the bus clock by a divider. A timeout of N seconds is therefore written as N*1000, and a 32-bit field covers the full range of 1 to 128 seconds.

The bus has no back-pressure. A write takes effect at the clock edge where it is presented. Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, the control word reads 0x0000_0020 (only the update-allowed bit 5 is set), the counter reads 0, the timeout reads DEFAULT_TOV and `rst_req` is low.
- R2: Writing 0x0000_C520 and then 0x0000_D928 to word 1 sets the unlocked flag, which is bit 11 of the control word.
- R3: A single write of 0xD928_C520 to word 1 unlocks only while the 32-bit command bit (bit 13) is set. While bit 13 is clear, the same value is an invalid key and raises `rst_req`.
- R4: A write to the timeout word (word 2) or to the control word is ignored unless the block is unlocked.
- R5: The unlocked flag clears UNLOCK_WINDOW clocks after the unlock, or at the first accepted control-word write, whichever comes first. Timeout-word writes leave the window open.
- R6: Any accepted configuration write sets the reconfiguration-success flag (bit 10), which stays set until reset.
- R7: The control-word write 0x0000_2120 sets bit 13 and bit 5 and leaves enable (bit 7) clear, so the counter does not advance.
- R8: While enable is set, the counter advances by one every TICK_DIV clocks, and reading word 1 returns its value.
- R9: While enabled, `rst_req` rises one clock after the counter reaches the timeout value. It then stays high until reset, even if a refresh arrives.
- R10: Writing 0xB480_A602 (with bit 13 set) or the halves 0x0000_A602 then 0x0000_B480 restarts the count at zero while the block is enabled. While the block is disabled, a refresh leaves the count unchanged.
- R11: Any other value written to word 1, including a wrong second half, raises `rst_req`.
- R12: Once bit 5 has been cleared by an accepted write, unlock keys are no longer honoured and no configuration is possible until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address (0 control, 1 counter/key, 2 timeout) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| rst_req | output | 1 | Sticky reset request |

## Verification
The bench builds the block with TICK_DIV=4, UNLOCK_WINDOW=16 and DEFAULT_TOV=60000. With a divider of 4, a timeout of a few ticks expires within tens of clocks, so the exact expiry edge can be checked for many random timeouts. The 16-clock window lets the bench reach window expiry without long waits. The large default timeout ensures that no run expires by accident before the bench configures the block.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int BIT_UPD   = 5;
  localparam int BIT_EN    = 7;
  localparam int BIT_RECFG = 10;
  localparam int BIT_UNL   = 11;
  localparam int BIT_CMD32 = 13;

  localparam logic [31:0] KEY_UNLOCK32  = 32'hD928_C520;
  localparam logic [31:0] KEY_REFRESH32 = 32'hB480_A602;
  localparam logic [31:0] KEY_UNLOCK_LO = 32'h0000_C520;
  localparam logic [31:0] KEY_UNLOCK_HI = 32'h0000_D928;
  localparam logic [31:0] KEY_REFR_LO   = 32'h0000_A602;
  localparam logic [31:0] KEY_REFR_HI   = 32'h0000_B480;

  typedef enum logic [1:0] {
    HALF_NONE,
    HALF_UNLOCK,
    HALF_REFRESH
  } half_state_e;
endpackage

// File: rtl/kwdt_key_decode.sv
module kwdt_key_decode
  import kwdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_wr,
  input  logic [31:0] key_data,
  input  logic        cmd32,
  output logic        unlock_hit,
  output logic        refresh_hit,
  output logic        bad_key
);
  half_state_e state_q, state_d;

  always_comb begin
    state_d     = state_q;
    unlock_hit  = 1'b0;
    refresh_hit = 1'b0;
    bad_key     = 1'b0;
    if (key_wr) begin
      state_d = HALF_NONE;
      unique case (state_q)
        HALF_UNLOCK: begin
          if (key_data == KEY_UNLOCK_HI) unlock_hit = 1'b1;
          else bad_key = 1'b1;
        end
        HALF_REFRESH: begin
          if (key_data == KEY_REFR_HI) refresh_hit = 1'b1;
          else bad_key = 1'b1;
        end
        default: begin
          if (cmd32 && key_data == KEY_UNLOCK32) unlock_hit = 1'b1;
          else if (cmd32 && key_data == KEY_REFRESH32) refresh_hit = 1'b1;
          else if (key_data == KEY_UNLOCK_LO) state_d = HALF_UNLOCK;
          else if (key_data == KEY_REFR_LO) state_d = HALF_REFRESH;
          else bad_key = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= HALF_NONE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/kwdt_unlock_win.sv
module kwdt_unlock_win #(
  parameter int UNLOCK_WINDOW = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic open_win,
  input  logic close_win,
  output logic unlocked
);
  localparam int WIN_W = $clog2(UNLOCK_WINDOW + 1);

  logic [WIN_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                left_q <= '0;
    else if (open_win)         left_q <= WIN_W'(UNLOCK_WINDOW);
    else if (close_win)        left_q <= '0;
    else if (left_q != '0)     left_q <= left_q - 1'b1;
  end

  assign unlocked = (left_q != '0);
endmodule

// File: rtl/kwdt_tick_cnt.sv
module kwdt_tick_cnt #(
  parameter int TICK_DIV = 50000,
  parameter int CNT_W    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             reached
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0] pre_q;
  logic             tick;

  assign tick = (pre_q == PRE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      count <= '0;
    end else if (run) begin
      if (restart) begin
        pre_q <= '0;
        count <= '0;
      end else begin
        pre_q <= tick ? '0 : pre_q + 1'b1;
        if (tick) count <= count + 1'b1;
      end
    end
  end

  assign reached = (count >= limit);
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import kwdt_pkg::*;
#(
  parameter int          ADDR_W        = 2,
  parameter int          CNT_W         = 32,
  parameter int          TICK_DIV      = 50000,
  parameter int          UNLOCK_WINDOW = 256,
  parameter logic [31:0] DEFAULT_TOV   = 32'd60000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              rst_req
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_TOV  = ADDR_W'(2);

  logic             en, upd, cmd32, recfg;
  logic             unlocked;
  logic [CNT_W-1:0] tov, count;
  logic             reached;
  logic             unlock_hit, refresh_hit, bad_key;
  logic             cfg_ok, wr_ctrl, wr_tov;

  assign cfg_ok  = unlocked && upd;
  assign wr_ctrl = bus_wr && bus_addr == A_CTRL && cfg_ok;
  assign wr_tov  = bus_wr && bus_addr == A_TOV && cfg_ok;

  kwdt_key_decode u_keys (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_wr     (bus_wr && bus_addr == A_CNT),
    .key_data   (bus_wdata),
    .cmd32      (cmd32),
    .unlock_hit (unlock_hit),
    .refresh_hit(refresh_hit),
    .bad_key    (bad_key)
  );

  kwdt_unlock_win #(.UNLOCK_WINDOW(UNLOCK_WINDOW)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .open_win (unlock_hit && upd),
    .close_win(wr_ctrl),
    .unlocked (unlocked)
  );

  kwdt_tick_cnt #(.TICK_DIV(TICK_DIV), .CNT_W(CNT_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (en),
    .restart(refresh_hit),
    .limit  (tov),
    .count  (count),
    .reached(reached)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      upd     <= 1'b1;
      cmd32   <= 1'b0;
      recfg   <= 1'b0;
      tov     <= CNT_W'(DEFAULT_TOV);
      rst_req <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en    <= bus_wdata[BIT_EN];
        upd   <= bus_wdata[BIT_UPD];
        cmd32 <= bus_wdata[BIT_CMD32];
      end
      if (wr_tov) tov <= bus_wdata[CNT_W-1:0];
      if (wr_ctrl || wr_tov) recfg <= 1'b1;
      if (bad_key || (en && reached)) rst_req <= 1'b1;
    end
  end

  logic [31:0] ctrl_word, rd_mux;

  always_comb begin
    ctrl_word            = '0;
    ctrl_word[BIT_UPD]   = upd;
    ctrl_word[BIT_EN]    = en;
    ctrl_word[BIT_RECFG] = recfg;
    ctrl_word[BIT_UNL]   = unlocked;
    ctrl_word[BIT_CMD32] = cmd32;
    unique case (bus_addr)
      A_CTRL:  rd_mux = ctrl_word;
      A_CNT:   rd_mux = 32'(count);
      A_TOV:   rd_mux = 32'(tov);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker #(
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              rst_req,
  input logic              unlocked,
  input logic              upd,
  input logic              en,
  input logic              recfg,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  tov
);
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);

  assert_expire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && count >= tov) |=> rst_req);

  assert_locked_tov_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && bus_wr && bus_addr == ADDR_W'(2)) |=> $stable(tov));

  assert_upd_stays_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> !upd);

  assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(count));

  assert_recfg_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recfg) |-> $past(bus_wr));
endmodule

bind keyed_wdt kwdt_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_wr  (bus_wr),
  .bus_addr(bus_addr),
  .rst_req (rst_req),
  .unlocked(unlocked),
  .upd     (upd),
  .en      (en),
  .recfg   (recfg),
  .count   (count),
  .tov     (tov)
);

// File: tb/test_keyed_wdt.sv
module test_keyed_wdt;
  localparam int TICK_DIV = 4;
  localparam int WIN      = 16;
  localparam logic [31:0] DEF_TOV = 32'd60000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  keyed_wdt #(.TICK_DIV(TICK_DIV), .UNLOCK_WINDOW(WIN), .DEFAULT_TOV(DEF_TOV)) i_keyed_wdt (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  function automatic logic [31:0] ctrl_exp(bit c32, bit unl, bit ok, bit en, bit upd);
    return {18'd0, c32, 1'b0, unl, ok, 2'b00, en, 1'b0, upd, 5'd0};
  endfunction

  function automatic int expiry_cycles(int t);
    return TICK_DIV * t;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic unlock16();
    wr(2'd1, 32'h0000_C520);
    wr(2'd1, 32'h0000_D928);
  endtask

  task automatic refresh16();
    wr(2'd1, 32'h0000_A602);
    wr(2'd1, 32'h0000_B480);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c1;
    void'($urandom(32'd4021));
    do_reset();
    // R1 reset state
    rd(2'd0, v); check("R1 ctrl", v, 32'h20);
    rd(2'd1, v); check("R1 count", v, 0);
    rd(2'd2, v); check("R1 tov", v, DEF_TOV);
    check("R1 rst_req", {31'd0, rst_req}, 0);
    // R4 locked writes ignored
    wr(2'd2, 32'd5);
    wr(2'd0, 32'h0000_20A0);
    rd(2'd2, v); check("R4 tov locked", v, DEF_TOV);
    rd(2'd0, v); check("R4 ctrl locked", v, 32'h20);
    // R2 16-bit unlock
    unlock16();
    rd(2'd0, v); check("R2 unlocked flag", v, ctrl_exp(0, 1, 0, 0, 1));
    // R4/R6 timeout write accepted, window stays open (R5)
    wr(2'd2, 32'd100);
    rd(2'd2, v); check("R4 tov accepted", v, 100);
    rd(2'd0, v); check("R6 recfg set", v, ctrl_exp(0, 1, 1, 0, 1));
    // R7 initial configuration write; R5 window closes
    wr(2'd0, 32'h0000_2120);
    rd(2'd0, v); check("R7 ctrl after init", v, ctrl_exp(1, 0, 1, 0, 1));
    repeat (20) @(negedge clk);
    rd(2'd1, v); check("R7 count stopped", v, 0);
    // R3 32-bit unlock, R5 window timeout
    wr(2'd1, 32'hD928_C520);
    rd(2'd0, v); check("R3 unlock32", v, ctrl_exp(1, 1, 1, 0, 1));
    repeat (WIN + 4) @(negedge clk);
    rd(2'd0, v); check("R5 window expired", v, ctrl_exp(1, 0, 1, 0, 1));
    wr(2'd2, 32'd7);
    rd(2'd2, v); check("R5 late tov ignored", v, 100);
    // enable, R8 count rate
    wr(2'd1, 32'hD928_C520);
    wr(2'd0, 32'h0000_20A0);
    wr(2'd1, 32'hB480_A602);
    repeat (20) @(negedge clk);
    rd(2'd1, v); check("R8 count after 20 clocks", v, 5);
    // R10 16-bit refresh
    refresh16();
    repeat (8) @(negedge clk);
    rd(2'd1, v); check("R10 refresh16 restart", v, 2);
    // R9 exact expiry
    wr(2'd1, 32'hB480_A602);
    repeat (expiry_cycles(100)) @(negedge clk);
    check("R9 not yet", {31'd0, rst_req}, 0);
    @(negedge clk);
    check("R9 expiry", {31'd0, rst_req}, 1);
    wr(2'd1, 32'hB480_A602);
    repeat (10) @(negedge clk);
    check("R9 sticky", {31'd0, rst_req}, 1);

    // R10 refresh while disabled
    do_reset();
    unlock16();
    wr(2'd0, 32'h0000_00A0);
    refresh16();
    repeat (20) @(negedge clk);
    unlock16();
    wr(2'd0, 32'h0000_0020);
    rd(2'd1, c1);
    check("R8 count moved", {31'd0, c1 != 0}, 1);
    refresh16();
    rd(2'd1, v); check("R10 disabled refresh", v, c1);
    check("R10 no rst_req", {31'd0, rst_req}, 0);

    // R12 update bit cleared
    do_reset();
    unlock16();
    wr(2'd0, 32'h0000_0000);
    unlock16();
    rd(2'd0, v); check("R12 no unlock", v, ctrl_exp(0, 0, 1, 0, 0));
    wr(2'd2, 32'd9);
    rd(2'd2, v); check("R12 tov frozen", v, DEF_TOV);

    // R11 bad keys, R3 32-bit key with bit 13 clear
    do_reset();
    wr(2'd1, 32'h0000_1234);
    check("R11 bad key", {31'd0, rst_req}, 1);
    do_reset();
    wr(2'd1, 32'h0000_C520);
    wr(2'd1, 32'h0000_1111);
    check("R11 bad second half", {31'd0, rst_req}, 1);
    do_reset();
    wr(2'd1, 32'hD928_C520);
    check("R3 key32 without cmd32", {31'd0, rst_req}, 1);

    // random timeouts and refresh styles (R9, R10)
    for (int i = 0; i < 6; i++) begin
      int t;
      t = 2 + int'($urandom % 10);
      do_reset();
      unlock16();
      wr(2'd2, 32'(t));
      wr(2'd0, 32'h0000_20A0);
      rd(2'd2, v); check("R4 random tov", v, 32'(t));
      if ($urandom % 2) wr(2'd1, 32'hB480_A602);
      else refresh16();
      repeat (expiry_cycles(t)) @(negedge clk);
      check("R9 random before", {31'd0, rst_req}, 0);
      @(negedge clk);
      check("R9 random expiry", {31'd0, rst_req}, 1);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule